// File: doc/BRIEF.md
# Frequency-Change Handshake Responder

This block is the register-side partner of one or more memory controllers that must switch the clock frequency they run at. Each controller raises a request line and presents a two-bit code that names the frequency set it wants: 0 for the boot/bypass clock, 1 for the first operating clock, 2 for the second. Code 3 is not a valid set. The block shows the pending request and the captured code in a read-only request register. It takes the software acknowledge through a separate acknowledge register and drives that acknowledge straight back to the controller.

Each switch is a four-phase exchange. The request rises, software writes the acknowledge to 1, the request falls, and software writes the acknowledge back to 0. Only then does the block count the exchange as complete and accept a new request. A shared target count says how many switches are expected, and each instance sets a done flag when it reaches that count. Two programmable cycle timers watch the waits. One watches the wait for a request to rise and the other watches the wait for it to fall after the acknowledge. Either timer sets a sticky error flag that software can read. Status flags clear only on reset.

Top module: `fchs_responder`

## Requirements
- R1: After reset every acknowledge output is 0, and every configuration word and every status word reads 0.
- R2: The request register of instance i sits at 0x80 + 0x10*i. Bit 7 shows the live request line. Bits [1:0] hold the code captured when the current or last exchange began. All other bits read 0. Bus writes to this address are ignored.
- R3: The acknowledge register of instance i sits at 0xC0 + 0x10*i. Bit 0 of a write is stored, drives that instance's acknowledge output from the next cycle, and reads back in bit 0. The output changes only on such a write.
- R4: An exchange counts as complete only after the request has fallen while the acknowledge is 1 and the acknowledge has then been written back to 0. The completion count then rises by exactly one.
- R5: A request that begins with code 3 sets a sticky invalid-code flag in status bit 1. The exchange still runs to completion and is counted.
- R6: Status bit 0 (done) is set when an instance's completion count reaches the target count at 0x00. A target of 0 never sets it.
- R7: The rise timer runs while an instance is idle, its request is low and its count is below the target. If the wait lasts more than the limit at 0x04 cycles, status bit 2 is set. A limit of 0 turns the timer off.
- R8: If the request stays high for more than the limit at 0x08 cycles after the acknowledge has been seen, status bit 3 is set. A limit of 0 turns this timer off.
- R9: A read returns its data, with a valid strobe, in the cycle after the read enable is sampled.
- R10: The status word of instance i sits at 0x40 + 0x10*i and carries the completion count in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlReq | input | NUM_INST | Frequency-change request, one line per controller |
| ctlCode | input | 2*NUM_INST | Requested frequency-set code, two bits per controller |
| ctlAck | output | NUM_INST | Acknowledge returned to each controller |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Register byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data |
| busRdValid | output | 1 | Read data valid, one cycle after the read strobe |

## Verification
The assertions check on every cycle that the read strobe is answered one cycle later and that each acknowledge line moves only on a write to its own register. They also check that the completion count steps by exactly one, and that each sticky flag rises only for its cause: a code-3 request for the invalid flag, a request still high under acknowledge for the fall timeout, and the count meeting the target for done. The bench scenarios show what no single-cycle property can. These are the timing of a count that waits for the acknowledge to return to 0, the code being held after the request drops, the rise timer firing on an armed idle instance but not on one that is already done, and the read-only behaviour of the request register.

// File: rtl/fchs_pkg.sv
package fchs_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 2;

  localparam int CFG_TARGET_OFS = 'h00;
  localparam int CFG_RISE_OFS   = 'h04;
  localparam int CFG_FALL_OFS   = 'h08;
  localparam int STAT_BASE      = 'h40;
  localparam int REQ_BASE       = 'h80;
  localparam int ACK_BASE       = 'hC0;
  localparam int INST_STRIDE    = 'h10;

  localparam logic [CODE_W-1:0] CODE_INVALID = 2'd3;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WAIT_ACK,
    HS_WAIT_FALL,
    HS_WAIT_CLR
  } hsState_e;

  typedef struct packed {
    logic capture;
    logic complete;
    logic riseRun;
    logic fallRun;
  } hsStrobe_t;
endpackage

// File: rtl/fchs_ctrl.sv
module fchs_ctrl
  import fchs_pkg::*;
#(
  parameter int NUM_INST = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_INST-1:0]            ctlReq,
  input  logic [NUM_INST-1:0]            ackBit,
  output hsStrobe_t [NUM_INST-1:0]       strobeVec
);
  for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
    hsState_e  stateQ, stateD;
    hsStrobe_t strobe;

    always_comb begin
      stateD = stateQ;
      strobe = '0;
      case (stateQ)
        HS_IDLE: begin
          strobe.riseRun = !ctlReq[i];
          if (ctlReq[i]) begin
            strobe.capture = 1'b1;
            stateD = HS_WAIT_ACK;
          end
        end
        HS_WAIT_ACK: begin
          if (ackBit[i]) stateD = HS_WAIT_FALL;
        end
        HS_WAIT_FALL: begin
          strobe.fallRun = ctlReq[i];
          if (!ctlReq[i]) stateD = HS_WAIT_CLR;
        end
        HS_WAIT_CLR: begin
          if (!ackBit[i]) begin
            strobe.complete = 1'b1;
            stateD = HS_IDLE;
          end
        end
        default: stateD = HS_IDLE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) stateQ <= HS_IDLE;
      else       stateQ <= stateD;
    end

    assign strobeVec[i] = strobe;
  end
endmodule

// File: rtl/fchs_datapath.sv
module fchs_datapath
  import fchs_pkg::*;
#(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 12,
  parameter int CNT_W    = 8,
  parameter int TMR_W    = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_INST-1:0]              ctlReq,
  input  logic [CODE_W*NUM_INST-1:0]       ctlCode,
  input  hsStrobe_t [NUM_INST-1:0]         strobeVec,
  input  logic                             busWrEn,
  input  logic                             busRdEn,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [DATA_W-1:0]                busWrData,
  output logic [DATA_W-1:0]                busRdData,
  output logic                             busRdValid,
  output logic [NUM_INST-1:0]              ackBit,
  output logic [NUM_INST-1:0][CNT_W-1:0]   hsCount,
  output logic [NUM_INST-1:0]              doneFlag,
  output logic [NUM_INST-1:0]              badCodeFlag,
  output logic [NUM_INST-1:0]              riseToFlag,
  output logic [NUM_INST-1:0]              fallToFlag,
  output logic [CNT_W-1:0]                 targetCount
);
  localparam logic [ADDR_W-1:0] TARGET_ADDR = ADDR_W'(CFG_TARGET_OFS);
  localparam logic [ADDR_W-1:0] RISE_ADDR   = ADDR_W'(CFG_RISE_OFS);
  localparam logic [ADDR_W-1:0] FALL_ADDR   = ADDR_W'(CFG_FALL_OFS);
  localparam logic [CNT_W-1:0]  CNT_MAX     = {CNT_W{1'b1}};

  logic [TMR_W-1:0] riseLimit, fallLimit;
  logic [NUM_INST-1:0][DATA_W-1:0] reqWordVec;
  logic [NUM_INST-1:0][DATA_W-1:0] statWordVec;
  logic [DATA_W-1:0] rdNext;

  // Shared configuration
  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetCount <= '0;
      riseLimit   <= '0;
      fallLimit   <= '0;
    end else if (busWrEn) begin
      if (busAddr == TARGET_ADDR) targetCount <= busWrData[CNT_W-1:0];
      if (busAddr == RISE_ADDR)   riseLimit   <= busWrData[TMR_W-1:0];
      if (busAddr == FALL_ADDR)   fallLimit   <= busWrData[TMR_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
    localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(ACK_BASE + i*INST_STRIDE);

    logic              ackR, doneR, badR, riseToR, fallToR;
    logic [CODE_W-1:0] codeR;
    logic [CNT_W-1:0]  cntR;
    logic [TMR_W-1:0]  riseTmr, fallTmr;
    logic              armed, riseGo, fallGo;

    assign armed  = cntR < targetCount;
    assign riseGo = strobeVec[i].riseRun && armed && (riseLimit != '0);
    assign fallGo = strobeVec[i].fallRun && (fallLimit != '0);

    always_ff @(posedge clk) begin
      if (!rstN)                                   ackR <= 1'b0;
      else if (busWrEn && busAddr == ACK_ADDR)     ackR <= busWrData[0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        codeR <= '0;
        badR  <= 1'b0;
      end else if (strobeVec[i].capture) begin
        codeR <= ctlCode[CODE_W*i +: CODE_W];
        if (ctlCode[CODE_W*i +: CODE_W] == CODE_INVALID) badR <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntR  <= '0;
        doneR <= 1'b0;
      end else if (strobeVec[i].complete) begin
        if (cntR != CNT_MAX) cntR <= cntR + 1'b1;
        if ((targetCount != '0) && (CNT_W'(cntR + 1'b1) == targetCount)) doneR <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        riseTmr <= '0;
        riseToR <= 1'b0;
      end else if (!riseGo) begin
        riseTmr <= '0;
      end else if (riseTmr == riseLimit) begin
        riseToR <= 1'b1;
      end else begin
        riseTmr <= riseTmr + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        fallTmr <= '0;
        fallToR <= 1'b0;
      end else if (!fallGo) begin
        fallTmr <= '0;
      end else if (fallTmr == fallLimit) begin
        fallToR <= 1'b1;
      end else begin
        fallTmr <= fallTmr + 1'b1;
      end
    end

    assign ackBit[i]      = ackR;
    assign hsCount[i]     = cntR;
    assign doneFlag[i]    = doneR;
    assign badCodeFlag[i] = badR;
    assign riseToFlag[i]  = riseToR;
    assign fallToFlag[i]  = fallToR;

    assign reqWordVec[i]  = DATA_W'({ctlReq[i], 5'b0, codeR});
    assign statWordVec[i] = DATA_W'({cntR, 4'b0, fallToR, riseToR, badR, doneR});
  end

  always_comb begin
    rdNext = '0;
    if (busAddr == TARGET_ADDR) rdNext = DATA_W'(targetCount);
    if (busAddr == RISE_ADDR)   rdNext = DATA_W'(riseLimit);
    if (busAddr == FALL_ADDR)   rdNext = DATA_W'(fallLimit);
    for (int k = 0; k < NUM_INST; k++) begin
      if (busAddr == ADDR_W'(REQ_BASE + k*INST_STRIDE))  rdNext = reqWordVec[k];
      if (busAddr == ADDR_W'(ACK_BASE + k*INST_STRIDE))  rdNext = DATA_W'(ackBit[k]);
      if (busAddr == ADDR_W'(STAT_BASE + k*INST_STRIDE)) rdNext = statWordVec[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData  <= '0;
      busRdValid <= 1'b0;
    end else begin
      busRdValid <= busRdEn;
      if (busRdEn) busRdData <= rdNext;
    end
  end
endmodule

// File: rtl/fchs_responder.sv
module fchs_responder
  import fchs_pkg::*;
#(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 12,
  parameter int CNT_W    = 8,
  parameter int TMR_W    = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_INST-1:0]          ctlReq,
  input  logic [2*NUM_INST-1:0]        ctlCode,
  output logic [NUM_INST-1:0]          ctlAck,
  input  logic                         busWrEn,
  input  logic                         busRdEn,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [31:0]                  busWrData,
  output logic [31:0]                  busRdData,
  output logic                         busRdValid
);
  hsStrobe_t [NUM_INST-1:0]       strobeVec;
  logic [NUM_INST-1:0][CNT_W-1:0] hsCount;
  logic [NUM_INST-1:0]            doneFlag, badCodeFlag, riseToFlag, fallToFlag;
  logic [CNT_W-1:0]               targetCount;

  fchs_ctrl #(.NUM_INST(NUM_INST)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctlReq    (ctlReq),
    .ackBit    (ctlAck),
    .strobeVec (strobeVec)
  );

  fchs_datapath #(
    .NUM_INST(NUM_INST), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TMR_W(TMR_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctlReq      (ctlReq),
    .ctlCode     (ctlCode),
    .strobeVec   (strobeVec),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .busRdValid  (busRdValid),
    .ackBit      (ctlAck),
    .hsCount     (hsCount),
    .doneFlag    (doneFlag),
    .badCodeFlag (badCodeFlag),
    .riseToFlag  (riseToFlag),
    .fallToFlag  (fallToFlag),
    .targetCount (targetCount)
  );
endmodule

// File: rtl/fchs_checker.sv
module fchs_checker #(
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 12,
  parameter int CNT_W    = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [NUM_INST-1:0]            ctlReq,
  input logic [2*NUM_INST-1:0]          ctlCode,
  input logic [NUM_INST-1:0]            ctlAck,
  input logic                           busWrEn,
  input logic                           busRdEn,
  input logic [ADDR_W-1:0]              busAddr,
  input logic [31:0]                    busWrData,
  input logic                           busRdValid,
  input logic [NUM_INST-1:0][CNT_W-1:0] hsCount,
  input logic [NUM_INST-1:0]            doneFlag,
  input logic [NUM_INST-1:0]            badCodeFlag,
  input logic [NUM_INST-1:0]            fallToFlag,
  input logic [CNT_W-1:0]               targetCount
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |=> busRdValid); // R9
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> !busRdValid); // R9

  for (genvar i = 0; i < NUM_INST; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'('hC0 + i*'h10);

    AST_ACK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && busAddr == ACK_ADDR) |=> (ctlAck[i] == $past(busWrData[0]))); // R3
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !(busWrEn && busAddr == ACK_ADDR) |=> $stable(ctlAck[i])); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (hsCount[i] != $past(hsCount[i])) |-> (hsCount[i] == CNT_W'($past(hsCount[i]) + 1'b1))); // R4
    AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
      $rose(doneFlag[i]) |-> (hsCount[i] == $past(targetCount))); // R6
    AST_BAD_CODE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(badCodeFlag[i]) |-> ($past(ctlReq[i]) && $past(ctlCode[2*i +: 2]) == 2'd3)); // R5
    AST_BAD_CODE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      $past(badCodeFlag[i]) |-> badCodeFlag[i]); // R5
    AST_FALL_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(fallToFlag[i]) |-> ($past(ctlReq[i]) && $past(ctlAck[i]))); // R8
  end
endmodule

bind fchs_responder fchs_checker #(
  .NUM_INST(NUM_INST), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ctlReq      (ctlReq),
  .ctlCode     (ctlCode),
  .ctlAck      (ctlAck),
  .busWrEn     (busWrEn),
  .busRdEn     (busRdEn),
  .busAddr     (busAddr),
  .busWrData   (busWrData),
  .busRdValid  (busRdValid),
  .hsCount     (hsCount),
  .doneFlag    (doneFlag),
  .badCodeFlag (badCodeFlag),
  .fallToFlag  (fallToFlag),
  .targetCount (targetCount)
);

// File: tb/fchs_responder_tb_top.sv
module fchs_responder_tb_top;
  localparam int NI = 2;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NI-1:0] ctlReq = '0;
  logic [2*NI-1:0] ctlCode = '0;
  logic [NI-1:0] ctlAck;
  logic          busWrEn = 1'b0;
  logic          busRdEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          busRdValid;

  int errCount = 0;
  int chkCount = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  fchs_responder #(.NUM_INST(NI), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .ctlReq(ctlReq), .ctlCode(ctlCode), .ctlAck(ctlAck),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .busRdValid(busRdValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read results as responses appear
  always @(negedge clk) begin
    if (rstN && busRdValid) begin
      if (expQ.size() == 0) check("R9 unexpected read response", 32'h1, 32'h0);
      else check(tagQ.pop_front(), busRdData, expQ.pop_front());
    end
  end

  task automatic busWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = AW'(addr); busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expectRead(input int addr, input logic [31:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = AW'(addr);
    @(negedge clk);
    busRdEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic raiseReq(input int inst, input logic [1:0] code);
    @(negedge clk);
    ctlReq[inst] = 1'b1;
    ctlCode[2*inst +: 2] = code;
    repeat (2) @(negedge clk);
  endtask

  task automatic dropReq(input int inst);
    @(negedge clk);
    ctlReq[inst] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic fullHandshake(input int inst, input logic [1:0] code, input int hold);
    raiseReq(inst, code);
    busWrite('hC0 + inst*'h10, 32'h1);
    repeat (hold) @(negedge clk);
    dropReq(inst);
    busWrite('hC0 + inst*'h10, 32'h0);
    repeat (3) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errCount++;
    chkCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 ack outputs after reset", 32'(ctlAck), 32'h0);
    expectRead('h40, 32'h0, "R1 status inst0 after reset");
    expectRead('h00, 32'h0, "R1 target after reset");
    expectRead('h80, 32'h0, "R2 request reg after reset");

    // R9: config readback
    busWrite('h00, 32'd2);
    expectRead('h00, 32'd2, "R9 target readback");

    // R2: request register ignores writes
    busWrite('h80, 32'hFF);
    expectRead('h80, 32'h0, "R2 write to request reg ignored");

    // Instance 0, code 1, step by step
    raiseReq(0, 2'd1);
    expectRead('h80, 32'h81, "R2 pending bit and code");
    expectRead('h40, 32'h0, "R4 no count before ack");
    busWrite('hC0, 32'h1);
    check("R3 ack output follows write", 32'(ctlAck), 32'h1);
    expectRead('hC0, 32'h1, "R3 ack readback");
    dropReq(0);
    expectRead('h80, 32'h01, "R2 code held after request falls");
    expectRead('h40, 32'h0, "R4 no count before ack cleared");
    busWrite('hC0, 32'h0);
    check("R3 ack output cleared", 32'(ctlAck), 32'h0);
    repeat (2) @(negedge clk);
    expectRead('h40, 32'h100, "R4 R10 count after first exchange");

    // Instance 1, invalid code 3
    fullHandshake(1, 2'd3, 1);
    expectRead('h50, 32'h102, "R5 invalid code flagged and counted");
    expectRead('h90, 32'h03, "R2 inst1 code captured");
    expectRead('h40, 32'h100, "R10 inst0 untouched by inst1");

    // Instance 0 second exchange reaches target
    fullHandshake(0, 2'd2, 1);
    expectRead('h40, 32'h201, "R6 done at target");

    // Rise timeout on armed idle instance only
    busWrite('h04, 32'd10);
    busWrite('h08, 32'd5);
    repeat (30) @(negedge clk);
    expectRead('h50, 32'h106, "R7 rise timeout on armed instance");
    expectRead('h40, 32'h201, "R7 no rise timeout once done");

    // Fall timeout: request held long after ack
    raiseReq(1, 2'd0);
    expectRead('h90, 32'h80, "R2 inst1 code 0 pending");
    busWrite('hD0, 32'h1);
    check("R3 inst1 ack only", 32'(ctlAck), 32'h2);
    repeat (12) @(negedge clk);
    dropReq(1);
    busWrite('hD0, 32'h0);
    repeat (3) @(negedge clk);
    expectRead('h50, 32'h20F, "R8 R6 fall timeout and done inst1");

    repeat (3) @(negedge clk);
    check("R9 all reads answered", 32'(expQ.size()), 32'h0);
    finishRun();
  end
endmodule